// File: doc/BRIEF.md
# Transmit Frame Word Loader

This block sits between a host and the byte-wide transmit port of an Ethernet MAC. The host loads a frame as 32-bit words. Every word but the final one goes through the normal push port into a small word FIFO. The final word goes through a separate closing port, together with a 2-bit count of its valid bytes. That closing write fixes the frame length and starts transmission. The final word is used even when the frame length is a multiple of four, in which case it carries all four bytes.

The block then hands bytes to the MAC, least-significant byte of each word first, under a valid/ready handshake. It flags the final byte of the frame. Lanes of the closing word beyond its byte count never leave the block. When the MAC reports the outcome, the block latches a status word and raises a sticky done flag. The host clears that flag by writing a one to the acknowledge input. A load-permitted output tells the host when a new frame may be loaded.

Top module: `tx_frame_loader`

## Requirements
- R1: After reset, `load_ok_o` is 1, `mac_valid_o` is 0, `done_o` is 0, `status_o` is 0 and `frame_len_o` is 0.
- R2: Words pushed with `push_i` leave on `mac_byte_o` in push order, each word least-significant byte first (bits 7:0, then 15:8, 23:16, 31:24), followed by the closing word.
- R3: The closing word's byte count is `last_bytes_i` (0 means 4 bytes, 1 to 3 mean that many); only that many low bytes of it are sent, and `mac_last_o` is 1 exactly on the final byte of the frame.
- R4: One cycle after the closing write, `frame_len_o` equals four times the number of accepted pushes plus the closing byte count.
- R5: From the closing write until the MAC reports completion, `load_ok_o` is 0, and writes on `push_i` or `last_i` are ignored: they change neither the bytes sent nor `frame_len_o`.
- R6: While `mac_valid_o` is 1 and `mac_ready_i` is 0, `mac_byte_o` and `mac_last_o` hold their values.
- R7: When `mac_done_i` arrives after the final byte, `done_o` goes to 1, `status_o[6:0]` takes `mac_res_i` (bit 0 ok, 1 deferred but sent, 2 late collision, 3 excess collisions, 4 excess deferral, 5 underrun, 6 oversize), `status_o[10:7]` takes `mac_col_i`, and `load_ok_o` returns to 1.
- R8: A one on `ack_i` clears `done_o` and the overflow bit `status_o[11]`; if completion arrives in the same cycle, `done_o` is set.
- R9: A push while the FIFO already holds `DEPTH` words is dropped and sets `status_o[11]`; the frame otherwise goes out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Queue `data_i` as a full frame word |
| last_i | input | 1 | Write `data_i` as the closing word and start sending |
| data_i | input | 32 | Word data for either write |
| last_bytes_i | input | 2 | Valid bytes in the closing word, 0 meaning 4 |
| ack_i | input | 1 | Write-one-to-clear for done and overflow |
| load_ok_o | output | 1 | A new frame may be loaded |
| frame_len_o | output | LW | Byte length of the last closed frame |
| done_o | output | 1 | Sticky transmit-complete flag |
| status_o | output | 12 | Overflow, collision count and outcome causes |
| mac_valid_o | output | 1 | A byte is offered to the MAC |
| mac_byte_o | output | 8 | Byte offered to the MAC |
| mac_last_o | output | 1 | Offered byte is the final byte of the frame |
| mac_ready_i | input | 1 | MAC takes the offered byte |
| mac_done_i | input | 1 | MAC reports the frame outcome |
| mac_res_i | input | 7 | Outcome cause bits from the MAC |
| mac_col_i | input | 4 | Collision count from the MAC |

## Verification
A wrong FIFO pointer or word count shows on the next byte the MAC takes, as a byte out of the numbered sequence or a frame of the wrong length. A wrong byte index shows within four bytes as a swapped lane. A fault in the closing-word count shows up in two places. The end flag lands on the wrong byte, and `frame_len_o` is wrong one cycle after the closing write. A stuck state shows as `load_ok_o` or `done_o` failing to change in the cycle after completion or acknowledge.

// File: rtl/tx_frame_loader.sv
module tx_frame_loader #(
  parameter int DEPTH = 8,
  parameter int LW    = $clog2(DEPTH*4+5)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          last_i,
  input  logic [31:0]   data_i,
  input  logic [1:0]    last_bytes_i,
  input  logic          ack_i,
  output logic          load_ok_o,
  output logic [LW-1:0] frame_len_o,
  output logic          done_o,
  output logic [11:0]   status_o,
  output logic          mac_valid_o,
  output logic [7:0]    mac_byte_o,
  output logic          mac_last_o,
  input  logic          mac_ready_i,
  input  logic          mac_done_i,
  input  logic [6:0]    mac_res_i,
  input  logic [3:0]    mac_col_i
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [1:0] {S_LOAD, S_SEND, S_WAIT} st_t;
  st_t st_q;

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic [31:0]   last_q;
  logic [2:0]    last_n_q;
  logic [1:0]    bidx_q;
  logic [LW-1:0] len_q;
  logic          done_q, ovf_q;
  logic [10:0]   res_q;

  logic        loading, push_ok, push_ovf, close, fire, word_end, pop;
  logic [2:0]  tail_n, cur_n;
  logic [31:0] cur_word;

  assign loading  = (st_q == S_LOAD);
  assign push_ok  = loading && push_i && (cnt_q != (AW+1)'(DEPTH));
  assign push_ovf = loading && push_i && (cnt_q == (AW+1)'(DEPTH));
  assign close    = loading && last_i;
  assign tail_n   = (last_bytes_i == 2'd0) ? 3'd4 : {1'b0, last_bytes_i};

  assign cur_word = (cnt_q != '0) ? mem[rp_q] : last_q;
  assign cur_n    = (cnt_q != '0) ? 3'd4 : last_n_q;
  assign word_end = ({1'b0, bidx_q} == cur_n - 3'd1);
  assign fire     = mac_valid_o && mac_ready_i;
  assign pop      = fire && word_end && (cnt_q != '0);

  assign mac_valid_o = (st_q == S_SEND);
  assign mac_byte_o  = cur_word[8*bidx_q +: 8];
  assign mac_last_o  = mac_valid_o && (cnt_q == '0) && word_end;
  assign load_ok_o   = loading;
  assign frame_len_o = len_q;
  assign done_o      = done_q;
  assign status_o    = {ovf_q, res_q};

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_LOAD;
      wp_q     <= '0;
      rp_q     <= '0;
      cnt_q    <= '0;
      last_q   <= '0;
      last_n_q <= 3'd4;
      bidx_q   <= '0;
      len_q    <= '0;
      done_q   <= 1'b0;
      ovf_q    <= 1'b0;
      res_q    <= '0;
    end else begin
      if (push_ok) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop)     rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      if (push_ok && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push_ok) cnt_q <= cnt_q - 1'b1;

      if (ack_i) ovf_q <= 1'b0;
      if (push_ovf) ovf_q <= 1'b1;

      if (ack_i) done_q <= 1'b0;

      case (st_q)
        S_LOAD: if (close) begin
          last_q   <= data_i;
          last_n_q <= tail_n;
          len_q    <= LW'({cnt_q, 2'b00}) + LW'(tail_n);
          bidx_q   <= '0;
          st_q     <= S_SEND;
        end
        S_SEND: if (fire) begin
          if (word_end) begin
            bidx_q <= '0;
            if (cnt_q == '0) st_q <= S_WAIT;
          end else begin
            bidx_q <= bidx_q + 1'b1;
          end
        end
        S_WAIT: if (mac_done_i) begin
          res_q  <= {mac_col_i, mac_res_i};
          done_q <= 1'b1;
          st_q   <= S_LOAD;
        end
        default: st_q <= S_LOAD;
      endcase
    end
  end
endmodule

module tx_frame_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic load_ok_o,
  input logic done_o,
  input logic ack_i,
  input logic mac_done_i,
  input logic mac_valid_o,
  input logic mac_ready_i,
  input logic [7:0] mac_byte_o,
  input logic mac_last_o
);
  a_r6_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    mac_valid_o && !mac_ready_i |=> mac_valid_o && $stable(mac_byte_o) && $stable(mac_last_o));
  a_r3_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    mac_last_o |-> mac_valid_o);
  a_r5_no_offer_while_loading: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok_o |-> !mac_valid_o);
  a_r7_done_on_return: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_ok_o) |-> done_o);
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && !mac_done_i |=> !done_o);
  a_r3_end_leaves_send: assert property (@(posedge clk) disable iff (!rst_n)
    mac_last_o && mac_ready_i |=> !mac_valid_o);
endmodule

bind tx_frame_loader tx_frame_loader_chk i_chk (
  .clk(clk), .rst_n(rst_n), .load_ok_o(load_ok_o), .done_o(done_o),
  .ack_i(ack_i), .mac_done_i(mac_done_i), .mac_valid_o(mac_valid_o),
  .mac_ready_i(mac_ready_i), .mac_byte_o(mac_byte_o), .mac_last_o(mac_last_o)
);

// File: tb/test_tx_frame_loader.sv
module test_tx_frame_loader;
  localparam int DEPTH = 8;
  localparam int LW = $clog2(DEPTH*4+5);

  logic clk = 0, rst_n = 0;
  logic push_i = 0, last_i = 0, ack_i = 0;
  logic [31:0] data_i = '0;
  logic [1:0] last_bytes_i = '0;
  logic load_ok_o, done_o, mac_valid_o, mac_last_o;
  logic [LW-1:0] frame_len_o;
  logic [11:0] status_o;
  logic [7:0] mac_byte_o;
  logic mac_ready_i = 0, mac_done_i = 0;
  logic [6:0] mac_res_i = '0;
  logic [3:0] mac_col_i = '0;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tx_frame_loader #(.DEPTH(DEPTH)) i_tx_frame_loader (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic logic [31:0] word_of(input int seed, input int k);
    return {8'(seed+4*k+3), 8'(seed+4*k+2), 8'(seed+4*k+1), 8'(seed+4*k)};
  endfunction

  function automatic logic [31:0] tail_of(input int seed, input int k, input int nb);
    logic [31:0] w;
    w = word_of(seed, k);
    for (int b = nb; b < 4; b++) w[8*b +: 8] = 8'hEE;
    return w;
  endfunction

  // one frame: npush full words, a closing word of nb bytes
  task automatic run_frame(input int npush, input int nb, input int seed, input bit stall,
                           input bit busy_poke, input bit ovf_poke,
                           input logic [6:0] res, input logic [3:0] col, input bit ack_same);
    int total, got, guard;
    total = 4*npush + nb;
    @(negedge clk);
    check(load_ok_o == 1, "R5 load_ok before frame", load_ok_o, 1);
    for (int k = 0; k < npush; k++) begin
      push_i = 1; data_i = word_of(seed, k);
      @(negedge clk);
    end
    if (ovf_poke) begin
      data_i = 32'hDEAD_BEEF;
      @(negedge clk);
      check(status_o[11] == 1, "R9 overflow bit set", status_o[11], 1);
    end
    push_i = 0;
    last_i = 1; last_bytes_i = 2'(nb % 4); data_i = tail_of(seed, npush, nb);
    @(negedge clk);
    last_i = 0;
    check(frame_len_o == LW'(total), "R4 frame length", frame_len_o, total);
    check(load_ok_o == 0, "R5 load_ok low while busy", load_ok_o, 0);
    if (busy_poke) begin
      push_i = 1; last_i = 1; last_bytes_i = 2'd1; data_i = 32'h5A5A_5A5A;
      @(negedge clk);
      push_i = 0; last_i = 0;
      check(frame_len_o == LW'(total), "R5 busy write ignored len", frame_len_o, total);
    end
    got = 0; guard = 0;
    while (got < total && guard < 500) begin
      mac_ready_i = stall ? (guard % 3 == 2) : 1'b1;
      #0;
      if (mac_valid_o && mac_ready_i) begin
        check(mac_byte_o == 8'(seed+got), "R2 byte order", mac_byte_o, 8'(seed+got));
        check(mac_last_o == (got == total-1), "R3 end flag", mac_last_o, got == total-1);
        got++;
      end
      guard++;
      @(negedge clk);
    end
    mac_ready_i = 0;
    check(got == total, "R3 byte count", got, total);
    check(mac_valid_o == 0 && load_ok_o == 0, "R7 waiting for MAC", mac_valid_o, 0);
    mac_done_i = 1; mac_res_i = res; mac_col_i = col; ack_i = ack_same;
    @(negedge clk);
    mac_done_i = 0; ack_i = 0;
    check(done_o == 1, ack_same ? "R8 set wins over ack" : "R7 done set", done_o, 1);
    check(status_o[10:0] == {col, res}, "R7 status captured", status_o[10:0], {col, res});
    check(load_ok_o == 1, "R7 load_ok returns", load_ok_o, 1);
  endtask

  task automatic do_ack();
    @(negedge clk);
    ack_i = 1;
    @(negedge clk);
    ack_i = 0;
    check(done_o == 0, "R8 ack clears done", done_o, 0);
    check(status_o[11] == 0, "R8 ack clears overflow", status_o[11], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(load_ok_o == 1 && mac_valid_o == 0, "R1 reset outputs", {load_ok_o, mac_valid_o}, 2);
    check(done_o == 0 && status_o == 0 && frame_len_o == 0, "R1 reset status", status_o, 0);
    rst_n = 1;
    run_frame(2, 4, 8'h10, 0, 0, 0, 7'h01, 4'd0, 0);   // R3 multiple of four
    do_ack();
    run_frame(3, 1, 8'h40, 1, 0, 0, 7'h02, 4'd3, 0);   // R6 stalls, 1-byte tail
    run_frame(1, 3, 8'h70, 0, 1, 0, 7'h04, 4'd7, 0);   // R5 busy writes
    do_ack();
    run_frame(0, 2, 8'hA0, 1, 0, 0, 7'h20, 4'd0, 1);   // R8 set wins, closing only
    do_ack();
    run_frame(DEPTH, 4, 8'h00, 0, 0, 1, 7'h40, 4'd15, 0); // R9 overflow
    check(status_o[11] == 1, "R9 overflow sticky", status_o[11], 1);
    do_ack();
    summary();
  end
endmodule